// File: doc/BRIEF.md
# Cycle-Exact Unsigned Word Divider

This unit divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. It returns a 16-bit quotient and a 16-bit remainder. Its latency is not fixed. The `done` strobe is held back until the exact number of clock cycles that a classic microcoded unsigned divide with a register operand would spend on the same operands. An emulator or a timing-accurate core uses it to get both the arithmetic result and the cycle cost of the instruction. The cost is also reported on `cycleCount`.

A pulse on `start` while the unit is idle captures both operands. Two short exits are checked first:
- A zero divisor raises `divByZero` and reports a cost of zero.
- An upper dividend half at or above the divisor raises `overflow` and costs a fixed ten cycles.

Neither exit writes the result registers.

Otherwise the unit runs a shift-and-subtract loop, one step per clock. The cost starts from a base and grows by a penalty on each of the first fifteen steps. The penalty depends on the bit shifted out of the top of the dividend and on the outcome of the compare. A counter then holds `done` low until the elapsed cycles equal that cost.

Top module: `udiv_cycle_exact`

## Requirements
- R1: For a non-zero divisor with dividend[31:16] < divisor, after `done` `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor.
- R2: When divisor is non-zero and dividend[31:16] >= divisor, `overflow` is 1, `divByZero` is 0 and `cycleCount` is 10.
- R3: An overflow or divide-by-zero operation leaves `quotient` and `remainder` at the values of the last completed normal divide.
- R4: For a normal divide, `cycleCount` is computed as follows. Start at 76. Then run the fifteen shift steps on a 32-bit working value, comparing it against divisor<<16:
  - If bit 31 was 1 before the shift, subtract and add 0.
  - Otherwise add 4, and if the shifted value is >= divisor<<16, subtract and take 2 back.
- R5: If `start` is sampled at clock edge t, `done` is high exactly in the cycle following edge t+`cycleCount`, for one cycle only.
- R6: A zero divisor sets `divByZero` to 1, `overflow` to 0 and `cycleCount` to 0, and `done` is high in the cycle right after the edge that sampled `start`.
- R7: `start` is ignored while an operation is in progress; the operands it carries have no effect on that operation's results or latency.
- R8: After reset `done`, `overflow`, `divByZero`, `quotient`, `remainder` and `cycleCount` are all 0.
- R9: Every normal divide reports a `cycleCount` between 76 and 136 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 16 | Unsigned divisor, sampled with start |
| quotient | output | 16 | Quotient of the last normal divide |
| remainder | output | 16 | Remainder of the last normal divide |
| overflow | output | 1 | Last operation overflowed |
| divByZero | output | 1 | Last operation had a zero divisor |
| done | output | 1 | One-cycle completion strobe |
| cycleCount | output | 8 | Cycle cost of the last operation |

## Verification
The assertions assume that `start` is only pulsed again after `done` has been seen. This lets them treat every `done` as the end of exactly one captured operation. They also assume the flags and cost it reports belong to that operation alone.

The bench drives each operation to its `done` before starting the next. The one exception is the deliberate mid-run `start` used for R7. That case is checked against results and latency, not against the pulse-pairing assertions.

Operand choices cover several cost patterns:
- zero and all-ones dividends;
- divisors near both ends of the range;
- the exact boundary where the upper dividend half equals the divisor.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, flags and initial cost
    logic step;    // perform one shift/subtract step
    logic costed;  // this step contributes to the cost
    logic last;    // final step: write the result registers
  } dpCtrl_t;
endpackage

// File: rtl/udiv_datapath.sv
module udiv_datapath
  import udiv_pkg::*;
#(
  parameter int W      = 16,
  parameter int BASE   = 38,
  parameter int OVF_MC = 5,
  parameter int CntW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctl,
  input  logic [2*W-1:0]  dividendIn,
  input  logic [W-1:0]    divisorIn,
  output logic [W-1:0]    quotient,
  output logic [W-1:0]    remainder,
  output logic            ovf,
  output logic            dz,
  output logic [CntW-1:0] cost
);
  localparam int DW = 2 * W;
  localparam logic [CntW-1:0] BaseClk   = CntW'(2 * BASE);
  localparam logic [CntW-1:0] OvfClk    = CntW'(2 * OVF_MC);
  localparam logic [CntW-1:0] HitClk    = CntW'(2);
  localparam logic [CntW-1:0] MissClk   = CntW'(4);

  logic [DW-1:0]   work;
  logic [W-1:0]    divisorR;
  logic            carry;
  logic [DW-1:0]   shifted;
  logic [W-1:0]    hi;
  logic            take;
  logic [DW-1:0]   nextWork;
  logic [CntW-1:0] stepCost;
  logic            zeroIn;
  logic            ovfIn;

  always_comb begin
    carry    = work[DW-1];
    shifted  = {work[DW-2:0], 1'b0};
    hi       = shifted[DW-1:W];
    take     = carry || (hi >= divisorR);
    nextWork = {take ? (hi - divisorR) : hi, shifted[W-1:1], take};
    if (carry)     stepCost = '0;
    else if (take) stepCost = HitClk;
    else           stepCost = MissClk;
    zeroIn = (divisorIn == '0);
    ovfIn  = !zeroIn && (dividendIn[DW-1:W] >= divisorIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work      <= '0;
      divisorR  <= '0;
      quotient  <= '0;
      remainder <= '0;
      ovf       <= 1'b0;
      dz        <= 1'b0;
      cost      <= '0;
    end else if (ctl.load) begin
      work     <= dividendIn;
      divisorR <= divisorIn;
      dz       <= zeroIn;
      ovf      <= ovfIn;
      if (zeroIn)     cost <= '0;
      else if (ovfIn) cost <= OvfClk;
      else            cost <= BaseClk;
    end else if (ctl.step) begin
      work <= nextWork;
      if (ctl.costed) cost <= cost + stepCost;
      if (ctl.last) begin
        quotient  <= nextWork[W-1:0];
        remainder <= nextWork[DW-1:W];
      end
    end
  end
endmodule

// File: rtl/udiv_sequencer.sv
module udiv_sequencer
  import udiv_pkg::*;
#(
  parameter int W    = 16,
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            skip,
  input  logic [CntW-1:0] cost,
  output dpCtrl_t         ctl,
  output logic            done
);
  localparam int StepW = $clog2(W + 1);
  localparam logic [StepW-1:0] LastIdx = StepW'(W - 1);
  localparam logic [StepW-1:0] EndIdx  = StepW'(W);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t       state;
  logic [StepW-1:0] stepIdx;
  logic [CntW-1:0]  elapsed;
  logic             stepsDone;

  always_comb begin
    stepsDone  = skip || (stepIdx == EndIdx);
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN) && !stepsDone;
    ctl.costed = ctl.step && (stepIdx < LastIdx);
    ctl.last   = ctl.step && (stepIdx == LastIdx);
    done       = (state == ST_RUN) && stepsDone && (elapsed == cost);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
      elapsed <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state   <= ST_RUN;
        stepIdx <= '0;
        elapsed <= '0;
      end
    end else begin
      if (ctl.step) stepIdx <= stepIdx + 1'b1;
      elapsed <= elapsed + 1'b1;
      if (done) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/udiv_cycle_exact.sv
module udiv_cycle_exact
  import udiv_pkg::*;
#(
  parameter int W      = 16,
  parameter int BASE   = 38,
  parameter int OVF_MC = 5
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     start,
  input  logic [2*W-1:0]                           dividend,
  input  logic [W-1:0]                             divisor,
  output logic [W-1:0]                             quotient,
  output logic [W-1:0]                             remainder,
  output logic                                     overflow,
  output logic                                     divByZero,
  output logic                                     done,
  output logic [$clog2(2*(BASE+2*(W-1))+1)-1:0]    cycleCount
);
  localparam int CntW = $clog2(2 * (BASE + 2 * (W - 1)) + 1);

  dpCtrl_t ctl;

  udiv_sequencer #(.W(W), .CntW(CntW)) seqU (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .skip  (overflow || divByZero),
    .cost  (cycleCount),
    .ctl   (ctl),
    .done  (done)
  );

  udiv_datapath #(.W(W), .BASE(BASE), .OVF_MC(OVF_MC), .CntW(CntW)) dpU (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dividendIn (dividend),
    .divisorIn  (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .ovf        (overflow),
    .dz         (divByZero),
    .cost       (cycleCount)
  );
endmodule

// File: rtl/udiv_checker.sv
module udiv_checker #(
  parameter int W      = 16,
  parameter int BASE   = 38,
  parameter int OVF_MC = 5,
  parameter int CntW   = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            done,
  input logic            overflow,
  input logic            divByZero,
  input logic [W-1:0]    quotient,
  input logic [W-1:0]    remainder,
  input logic [CntW-1:0] cycleCount
);
  localparam logic [CntW-1:0] MinClk = CntW'(2 * BASE);
  localparam logic [CntW-1:0] MaxClk = CntW'(2 * (BASE + 2 * (W - 1)));
  localparam logic [CntW-1:0] OvfClk = CntW'(2 * OVF_MC);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  normal_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflow && !divByZero) |-> (cycleCount >= MinClk && cycleCount <= MaxClk));

  // R2
  ovf_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (cycleCount == OvfClk && !divByZero));

  // R6
  zero_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && divByZero) |-> (cycleCount == '0 && !overflow));

  // R3
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow || divByZero) |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind udiv_cycle_exact udiv_checker #(.W(W), .BASE(BASE), .OVF_MC(OVF_MC), .CntW(CntW)) chkU (
  .clk        (clk),
  .rstN       (rstN),
  .done       (done),
  .overflow   (overflow),
  .divByZero  (divByZero),
  .quotient   (quotient),
  .remainder  (remainder),
  .cycleCount (cycleCount)
);

// File: tb/tb_udiv_cycle_exact.sv
module tb_udiv_cycle_exact;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [15:0] quotient, remainder;
  logic        overflow, divByZero, done;
  logic [7:0]  cycleCount;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  udiv_cycle_exact dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .overflow(overflow),
    .divByZero(divByZero), .done(done), .cycleCount(cycleCount)
  );

  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {32'd100,        16'd7},
    {32'h0000_0000,  16'd1},
    {32'h1234_5678,  16'h9ABC},
    {32'h7FFF_FFFF,  16'h8000},
    {32'hFFFE_FFFF,  16'hFFFF},
    {32'h0005_0000,  16'd5},
    {32'hFFFF_FFFF,  16'h0000},
    {32'h0004_FFFF,  16'd5},
    {32'hFFFF_FFFF,  16'hFFFF},
    {32'h0000_FFFF,  16'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [15:0] b,
                       output int q, output int r, output int cnt,
                       output bit ovf, output bit dz);
    logic [31:0] d, h;
    bit carry;
    q = 0; r = 0; ovf = 0; dz = 0;
    if (b == 0) begin dz = 1; cnt = 0; end
    else if (a[31:16] >= b) begin ovf = 1; cnt = 10; end
    else begin
      q = int'(a / {16'd0, b});
      r = int'(a % {16'd0, b});
      cnt = 76;
      d = a; h = {b, 16'd0};
      for (int i = 0; i < 15; i++) begin
        carry = d[31];
        d = d << 1;
        if (carry) d = d - h;
        else begin
          cnt += 4;
          if (d >= h) begin d = d - h; cnt -= 2; end
        end
      end
    end
  endtask

  // Issues start, returns number of edges after the start edge until done is seen
  task automatic launch(input logic [31:0] a, input logic [15:0] b, output int lat);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int q, r, cnt, lat;
    bit ovf, dz;
    logic [15:0] lastQ, lastR;

    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk(done == 0, "R8", "done", done, 0);
    chk(quotient == 0 && remainder == 0, "R8", "result", {quotient, remainder}, 0);
    chk(overflow == 0 && divByZero == 0, "R8", "flags", {overflow, divByZero}, 0);
    chk(cycleCount == 0, "R8", "count", cycleCount, 0);
    @(negedge clk); rstN = 1'b1;
    lastQ = 0; lastR = 0;

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][47:16], VEC[i][15:0], q, r, cnt, ovf, dz);
      launch(VEC[i][47:16], VEC[i][15:0], lat);
      // R5 latency matches reported count
      chk(lat == cnt, "R5", "latency", lat, cnt);
      chk(overflow == ovf, "R2", "overflow flag", overflow, ovf);
      chk(divByZero == dz, "R6", "zero flag", divByZero, dz);
      if (dz) begin
        chk(cycleCount == 0 && lat == 0, "R6", "zero cost", cycleCount, 0);
        chk(quotient == lastQ && remainder == lastR, "R3", "kept result",
            {quotient, remainder}, {lastQ, lastR});
      end else if (ovf) begin
        chk(cycleCount == 10, "R2", "overflow cost", cycleCount, 10);
        chk(quotient == lastQ && remainder == lastR, "R3", "kept result",
            {quotient, remainder}, {lastQ, lastR});
      end else begin
        chk(int'(quotient) == q, "R1", "quotient", quotient, q);
        chk(int'(remainder) == r, "R1", "remainder", remainder, r);
        chk(int'(cycleCount) == cnt, "R4", "cost", cycleCount, cnt);
        chk(cycleCount >= 76 && cycleCount <= 136, "R9", "cost range", cycleCount, cnt);
        lastQ = quotient; lastR = remainder;
      end
      @(posedge clk); #1;
      // R5 single-cycle pulse
      chk(done == 0, "R5", "done pulse width", done, 0);
    end

    // R7 start during a run is ignored
    model(32'd1000, 16'd33, q, r, cnt, ovf, dz);
    @(negedge clk);
    dividend = 32'd1000; divisor = 16'd33; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    repeat (5) begin @(posedge clk); #1; lat++; end
    dividend = 32'h0005_0000; divisor = 16'd0; start = 1'b1;
    @(posedge clk); #1; lat++;
    start = 1'b0;
    while (!done && lat < 400) begin @(posedge clk); #1; lat++; end
    chk(lat == cnt, "R7", "latency", lat, cnt);
    chk(int'(quotient) == q && int'(remainder) == r, "R7", "result",
        {quotient, remainder}, {q[15:0], r[15:0]});
    chk(overflow == 0 && divByZero == 0, "R7", "flags", {overflow, divByZero}, 0);
    @(posedge clk); #1;

    finishRun();
  end
endmodule